// File: doc/BRIEF.md
# I2C Target Address Alias Router

This block is the address stage of a bridge that appears on a local I2C bus as a target. It watches the already-synchronised SCL and SDA levels, finds START and repeated START conditions, and shifts in the first byte of each transfer. It then decides whether the transfer belongs to this device, should be sent across to a remote link, or should be left alone. For transfers that are sent across, the 7-bit address may be rewritten.

The device's own address comes either from a strap value or from a register value, chosen by an override bit. Transfers leave the device through three paths. The first is an alias entry, which swaps the address for a physical remote address. The second is a remote-device ID, which keeps the address unchanged. The third is a pass-all mode, which sends on every address that is not local. A global forwarding enable gates all three paths. The block reports each decision as a single-cycle pulse carrying a route code and the outgoing byte. It also drives an acknowledge request that the pad logic turns into SDA held low during the ninth clock.

Top module: `alias_router`

## Requirements
- R1: The local address is `strap_id_i` when `id_override_i` is 0 and `reg_id_i` when it is 1. An address byte whose upper 7 bits equal the local address is routed local (code 1), and its byte is reported unchanged.
- R2: A byte whose upper 7 bits equal a nonzero `alias_id_i` is routed forward (code 2). It is reported as {`phys_id_i`, received bit 0}, so the R/W bit is kept.
- R3: A byte whose upper 7 bits equal a nonzero `remote_id_i` is routed forward with its byte unchanged. When the byte also matches the alias, the alias takes priority.
- R4: An alias value of 0 or a remote ID value of 0 disables that entry. Address 0 then does not match it.
- R5: With `pass_all_i` set, every non-local address is forwarded unchanged. With it clear, addresses that match neither entry are ignored (code 0) and reported unchanged.
- R6: A local match takes priority over the alias, the remote-ID entry and pass-all.
- R7: With `fwd_en_i` clear, no address is forwarded. Non-local addresses are ignored.
- R8: `ack_drive_o` goes high from the SCL fall after the eighth address bit until the next SCL fall, and only when the address should be acknowledged. A local address is always acknowledged. An ignored address never is. A forwarded address is acknowledged when `auto_ack_i` is set and bit 0 is 0 (a write), or when `remote_ack_i` is high at the eighth rising SCL edge.
- R9: `dec_valid_o` is high for exactly one clock per address byte, in the cycle after the eighth rising SCL edge is sampled. Data bits after the acknowledge produce no further pulse.
- R10: A START or repeated START restarts address capture from bit 0. A STOP before the eighth bit abandons the byte with no decision and no acknowledge.
- R11: After reset, `dec_valid_o`, `dec_kind_o` and `ack_drive_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| strap_id_i | input | 7 | Strap-derived local address |
| reg_id_i | input | 7 | Register-programmed local address |
| id_override_i | input | 1 | 1 selects the register address |
| fwd_en_i | input | 1 | Forwarding enable |
| pass_all_i | input | 1 | Forward every non-local address |
| auto_ack_i | input | 1 | Acknowledge forwarded writes at once |
| remote_id_i | input | 7 | Remote-device address, 0 disables |
| alias_id_i | input | 7 | Alias address, 0 disables |
| phys_id_i | input | 7 | Physical remote address for the alias |
| remote_ack_i | input | 1 | Remote side acknowledged |
| dec_valid_o | output | 1 | One-cycle decision pulse |
| dec_kind_o | output | 2 | 0 ignore, 1 local, 2 forward |
| dec_addr_o | output | 8 | Outgoing address byte with R/W bit |
| ack_drive_o | output | 1 | Request to hold SDA low |

## Verification
The assertions check on every cycle that the decision pulse lasts one cycle and never carries an unused code. They also check that a local decision names the local address that was selected, that nothing is forwarded while forwarding is disabled, and that an acknowledge never follows an ignored address. Only the bench's scenarios can show address translation, zero-entry disabling, pass-all and priority ordering, the auto-acknowledge write/read split, and the effect of repeated START and early STOP on capture.

// File: rtl/alias_rtr_pkg.sv
package alias_rtr_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        RT_IGNORE  = 2'd0,
        RT_LOCAL   = 2'd1,
        RT_FORWARD = 2'd2
    } route_e;

    typedef struct packed {
        route_e              kind;
        logic [BYTE_W-1:0]   addr;
        logic                ack;
    } route_t;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_ADDR     = 3'd1,
        PH_WAIT_ACK = 3'd2,
        PH_ACK      = 3'd3,
        PH_DATA     = 3'd4
    } phase_e;

    function automatic logic [ADDR_W-1:0] pick_local(
        input logic [ADDR_W-1:0] strap,
        input logic [ADDR_W-1:0] regv,
        input logic              ovr
    );
        return ovr ? regv : strap;
    endfunction
endpackage

// File: rtl/rtr_bus_cond.sv
module rtr_bus_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        start_o    = scl_q & scl_i & sda_q & ~sda_i;
        stop_o     = scl_q & scl_i & ~sda_q & sda_i;
        scl_rise_o = ~scl_q & scl_i;
        scl_fall_o = scl_q & ~scl_i;
    end
endmodule

// File: rtl/rtr_addr_capture.sv
module rtr_addr_capture
    import alias_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_i,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              ack_begin_o,
    output logic              ack_end_o
);
    phase_e              phase_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [BYTE_W-2:0]   shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (start_i) begin
            phase_q <= PH_ADDR;
            cnt_q   <= '0;
        end else if (stop_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_ADDR: begin
                    if (scl_rise_i) begin
                        shift_q <= {shift_q[BYTE_W-3:0], sda_i};
                        cnt_q   <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(BYTE_W - 1))
                            phase_q <= PH_WAIT_ACK;
                    end
                end
                PH_WAIT_ACK: if (scl_fall_i) phase_q <= PH_ACK;
                PH_ACK:      if (scl_fall_i) phase_q <= PH_DATA;
                default:     phase_q <= phase_q;
            endcase
        end
    end

    always_comb begin
        byte_o       = {shift_q, sda_i};
        byte_valid_o = (phase_q == PH_ADDR) && scl_rise_i && !start_i && !stop_i
                       && (cnt_q == CNT_W'(BYTE_W - 1));
        ack_begin_o  = (phase_q == PH_WAIT_ACK) && scl_fall_i;
        ack_end_o    = (phase_q == PH_ACK) && scl_fall_i;
    end
endmodule

// File: rtl/rtr_decide.sv
module rtr_decide
    import alias_rtr_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] strap_id_i,
    input  logic [ADDR_W-1:0] reg_id_i,
    input  logic              id_override_i,
    input  logic              fwd_en_i,
    input  logic              pass_all_i,
    input  logic              auto_ack_i,
    input  logic [ADDR_W-1:0] remote_id_i,
    input  logic [ADDR_W-1:0] alias_id_i,
    input  logic [ADDR_W-1:0] phys_id_i,
    input  logic              remote_ack_i,
    output route_t            route_o
);
    logic [ADDR_W-1:0] tgt;
    logic              rw;
    logic              hit_local;
    logic              hit_alias;
    logic              hit_remote;
    logic              fwd_ack;

    always_comb begin
        tgt        = byte_i[BYTE_W-1:1];
        rw         = byte_i[0];
        hit_local  = (tgt == pick_local(strap_id_i, reg_id_i, id_override_i));
        hit_alias  = (alias_id_i != '0) && (tgt == alias_id_i);
        hit_remote = (remote_id_i != '0) && (tgt == remote_id_i);
        fwd_ack    = (auto_ack_i & ~rw) | remote_ack_i;

        route_o.kind = RT_IGNORE;
        route_o.addr = byte_i;
        route_o.ack  = 1'b0;
        if (hit_local) begin
            route_o.kind = RT_LOCAL;
            route_o.ack  = 1'b1;
        end else if (fwd_en_i) begin
            if (hit_alias) begin
                route_o.kind = RT_FORWARD;
                route_o.addr = {phys_id_i, rw};
                route_o.ack  = fwd_ack;
            end else if (hit_remote || pass_all_i) begin
                route_o.kind = RT_FORWARD;
                route_o.ack  = fwd_ack;
            end
        end
    end
endmodule

// File: rtl/alias_router.sv
module alias_router
    import alias_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] strap_id_i,
    input  logic [ADDR_W-1:0] reg_id_i,
    input  logic              id_override_i,
    input  logic              fwd_en_i,
    input  logic              pass_all_i,
    input  logic              auto_ack_i,
    input  logic [ADDR_W-1:0] remote_id_i,
    input  logic [ADDR_W-1:0] alias_id_i,
    input  logic [ADDR_W-1:0] phys_id_i,
    input  logic              remote_ack_i,
    output logic              dec_valid_o,
    output logic [1:0]        dec_kind_o,
    output logic [BYTE_W-1:0] dec_addr_o,
    output logic              ack_drive_o
);
    logic              start_w, stop_w, rise_w, fall_w;
    logic              byte_valid_w, ack_begin_w, ack_end_w;
    logic [BYTE_W-1:0] byte_w;
    route_t            route_w;
    route_t            dec_q;
    logic              dec_valid_q;
    logic              ack_q;

    rtr_bus_cond cond_i (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .start_o    (start_w),
        .stop_o     (stop_w),
        .scl_rise_o (rise_w),
        .scl_fall_o (fall_w)
    );

    rtr_addr_capture cap_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_w),
        .stop_i       (stop_w),
        .scl_rise_i   (rise_w),
        .scl_fall_i   (fall_w),
        .sda_i        (sda_i),
        .byte_valid_o (byte_valid_w),
        .byte_o       (byte_w),
        .ack_begin_o  (ack_begin_w),
        .ack_end_o    (ack_end_w)
    );

    rtr_decide dec_i (
        .byte_i        (byte_w),
        .strap_id_i    (strap_id_i),
        .reg_id_i      (reg_id_i),
        .id_override_i (id_override_i),
        .fwd_en_i      (fwd_en_i),
        .pass_all_i    (pass_all_i),
        .auto_ack_i    (auto_ack_i),
        .remote_id_i   (remote_id_i),
        .alias_id_i    (alias_id_i),
        .phys_id_i     (phys_id_i),
        .remote_ack_i  (remote_ack_i),
        .route_o       (route_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid_q <= 1'b0;
            dec_q       <= '{kind: RT_IGNORE, addr: '0, ack: 1'b0};
            ack_q       <= 1'b0;
        end else begin
            dec_valid_q <= byte_valid_w;
            if (byte_valid_w)
                dec_q <= route_w;
            if (start_w || stop_w || ack_end_w)
                ack_q <= 1'b0;
            else if (ack_begin_w)
                ack_q <= dec_q.ack;
        end
    end

    always_comb begin
        dec_valid_o = dec_valid_q;
        dec_kind_o  = dec_q.kind;
        dec_addr_o  = dec_q.addr;
        ack_drive_o = ack_q;
    end
endmodule

// File: rtl/alias_router_chk.sv
module alias_router_chk
    import alias_rtr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dec_valid_o,
    input logic [1:0]        dec_kind_o,
    input logic [BYTE_W-1:0] dec_addr_o,
    input logic              ack_drive_o,
    input logic [ADDR_W-1:0] strap_id_i,
    input logic [ADDR_W-1:0] reg_id_i,
    input logic              id_override_i,
    input logic              fwd_en_i
);
    logic [1:0] last_kind;

    always_ff @(posedge clk) begin
        if (rst)
            last_kind <= 2'd0;
        else if (dec_valid_o)
            last_kind <= dec_kind_o;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dec_valid_o |=> !dec_valid_o); // R9
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        dec_valid_o |-> dec_kind_o != 2'd3); // R9
    AST_LOCAL_ID_MATCH: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && dec_kind_o == 2'd1) |->
        dec_addr_o[BYTE_W-1:1] == ($past(id_override_i) ? $past(reg_id_i) : $past(strap_id_i))); // R1
    AST_NO_FWD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && !$past(fwd_en_i)) |-> dec_kind_o != 2'd2); // R7
    AST_NO_ACK_ON_IGNORE: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_drive_o) |-> last_kind != 2'd0); // R8
endmodule

bind alias_router alias_router_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .dec_valid_o   (dec_valid_o),
    .dec_kind_o    (dec_kind_o),
    .dec_addr_o    (dec_addr_o),
    .ack_drive_o   (ack_drive_o),
    .strap_id_i    (strap_id_i),
    .reg_id_i      (reg_id_i),
    .id_override_i (id_override_i),
    .fwd_en_i      (fwd_en_i)
);

// File: tb/alias_router_tb_top.sv
module alias_router_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1, sda = 1'b1;
    logic [6:0] strap_id, reg_id, remote_id, alias_id, phys_id;
    logic       ovr, fwd_en, pass_all, auto_ack, remote_ack;
    logic       dec_valid, ack_drive;
    logic [1:0] dec_kind;
    logic [7:0] dec_addr;

    int total = 0;
    int bad   = 0;
    int pulses = 0;
    logic [1:0] cap_kind;
    logic [7:0] cap_addr;

    always #10 clk = ~clk;

    alias_router dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .strap_id_i(strap_id), .reg_id_i(reg_id), .id_override_i(ovr),
        .fwd_en_i(fwd_en), .pass_all_i(pass_all), .auto_ack_i(auto_ack),
        .remote_id_i(remote_id), .alias_id_i(alias_id), .phys_id_i(phys_id),
        .remote_ack_i(remote_ack), .dec_valid_o(dec_valid), .dec_kind_o(dec_kind),
        .dec_addr_o(dec_addr), .ack_drive_o(ack_drive)
    );

    always @(negedge clk) begin
        if (!rst && dec_valid) begin
            pulses   <= pulses + 1;
            cap_kind <= dec_kind;
            cap_addr <= dec_addr;
        end
    end

    typedef struct packed {
        logic [6:0] strap, regid;
        logic       ovr, fwd, pa, aa;
        logic [6:0] rem, ali, phy;
        logic       rack;
        logic [7:0] byt;
        logic [1:0] ekind;
        logic [7:0] eaddr;
        logic       eack;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{7'h0C,7'h20,1'b0,1'b1,1'b0,1'b0,7'h30,7'h40,7'h50,1'b0,8'h18,2'd1,8'h18,1'b1}, // R1 strap
        '{7'h0C,7'h20,1'b1,1'b1,1'b0,1'b0,7'h30,7'h40,7'h50,1'b0,8'h18,2'd0,8'h18,1'b0}, // R1 override, R5 ignore
        '{7'h0C,7'h20,1'b1,1'b1,1'b0,1'b0,7'h30,7'h40,7'h50,1'b0,8'h41,2'd1,8'h41,1'b1}, // R1 register id
        '{7'h0C,7'h20,1'b0,1'b1,1'b0,1'b1,7'h30,7'h40,7'h50,1'b0,8'h80,2'd2,8'hA0,1'b1}, // R2 write auto-ack
        '{7'h0C,7'h20,1'b0,1'b1,1'b0,1'b1,7'h30,7'h40,7'h50,1'b0,8'h81,2'd2,8'hA1,1'b0}, // R2 R8 read no auto
        '{7'h0C,7'h20,1'b0,1'b1,1'b0,1'b0,7'h30,7'h40,7'h50,1'b1,8'h81,2'd2,8'hA1,1'b1}, // R8 remote ack
        '{7'h0C,7'h20,1'b0,1'b1,1'b0,1'b0,7'h30,7'h40,7'h50,1'b0,8'h60,2'd2,8'h60,1'b0}, // R3 remote id
        '{7'h0C,7'h20,1'b0,1'b1,1'b0,1'b0,7'h30,7'h00,7'h50,1'b0,8'h00,2'd0,8'h00,1'b0}, // R4 alias zero
        '{7'h0C,7'h20,1'b0,1'b1,1'b0,1'b0,7'h00,7'h40,7'h50,1'b0,8'h00,2'd0,8'h00,1'b0}, // R4 remote zero
        '{7'h0C,7'h20,1'b0,1'b1,1'b1,1'b1,7'h30,7'h40,7'h50,1'b0,8'h22,2'd2,8'h22,1'b1}, // R5 pass-all
        '{7'h0C,7'h20,1'b0,1'b1,1'b1,1'b1,7'h30,7'h40,7'h50,1'b0,8'h18,2'd1,8'h18,1'b1}, // R6 over pass-all
        '{7'h0C,7'h20,1'b0,1'b0,1'b1,1'b1,7'h30,7'h40,7'h50,1'b1,8'h80,2'd0,8'h80,1'b0}, // R7 gate off
        '{7'h0C,7'h20,1'b0,1'b1,1'b0,1'b1,7'h30,7'h0C,7'h50,1'b0,8'h18,2'd1,8'h18,1'b1}, // R6 over alias
        '{7'h0C,7'h20,1'b0,1'b1,1'b0,1'b0,7'h40,7'h40,7'h50,1'b1,8'h80,2'd2,8'hA0,1'b1}  // R3 alias first
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; scl = 1'b1; wclk(3);
        sda = 1'b0; wclk(3);
        scl = 1'b0; wclk(3);
    endtask

    task automatic bus_restart();
        sda = 1'b1; wclk(3);
        scl = 1'b1; wclk(3);
        sda = 1'b0; wclk(3);
        scl = 1'b0; wclk(3);
    endtask

    task automatic bus_stop();
        sda = 1'b0; wclk(3);
        scl = 1'b1; wclk(3);
        sda = 1'b1; wclk(3);
    endtask

    task automatic bus_bit(input logic b);
        sda = b; wclk(3);
        scl = 1'b1; wclk(3);
        scl = 1'b0; wclk(3);
    endtask

    task automatic bus_byte(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) bus_bit(b[k]);
    endtask

    task automatic ack_slot(output logic got, output logic after);
        sda = 1'b1; wclk(3);
        scl = 1'b1; wclk(3);
        got = ack_drive;
        scl = 1'b0; wclk(3);
        after = ack_drive;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t v;
        logic got, after;
        int p0;
        strap_id = 7'h0C; reg_id = 7'h20; ovr = 0; fwd_en = 1; pass_all = 0;
        auto_ack = 0; remote_id = 7'h30; alias_id = 7'h40; phys_id = 7'h50; remote_ack = 0;
        wclk(4);
        check(dec_valid == 1'b0, "R11 valid", dec_valid, 0);
        check(dec_kind == 2'd0,  "R11 kind", dec_kind, 0);
        check(ack_drive == 1'b0, "R11 ack", ack_drive, 0);
        rst = 1'b0;
        wclk(2);

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            strap_id = v.strap; reg_id = v.regid; ovr = v.ovr; fwd_en = v.fwd;
            pass_all = v.pa; auto_ack = v.aa; remote_id = v.rem; alias_id = v.ali;
            phys_id = v.phy; remote_ack = v.rack;
            p0 = pulses;
            bus_start();
            bus_byte(v.byt);
            ack_slot(got, after);
            bus_stop();
            check(pulses - p0 == 1, $sformatf("R9 pulse count v%0d", i), pulses - p0, 1);
            check(cap_kind == v.ekind, $sformatf("route kind v%0d", i), cap_kind, v.ekind);
            check(cap_addr == v.eaddr, $sformatf("route addr v%0d", i), cap_addr, v.eaddr);
            check(got == v.eack, $sformatf("R8 ack v%0d", i), got, v.eack);
            check(after == 1'b0, $sformatf("R8 release v%0d", i), after, 0);
        end

        strap_id = 7'h0C; ovr = 0; fwd_en = 1; pass_all = 0; auto_ack = 0;
        remote_id = 7'h30; alias_id = 7'h40; remote_ack = 0;

        // R10 repeated START restarts capture
        p0 = pulses;
        bus_start();
        for (int k = 0; k < 4; k++) bus_bit(1'b1);
        bus_restart();
        bus_byte(8'h18);
        ack_slot(got, after);
        bus_stop();
        check(pulses - p0 == 1, "R10 restart pulses", pulses - p0, 1);
        check(cap_addr == 8'h18, "R10 restart addr", cap_addr, 8'h18);
        check(got == 1'b1, "R10 restart ack", got, 1);

        // R10 STOP before eighth bit abandons the byte
        p0 = pulses;
        bus_start();
        for (int k = 0; k < 5; k++) bus_bit(1'b0);
        bus_stop();
        wclk(4);
        check(pulses - p0 == 0, "R10 early stop pulses", pulses - p0, 0);
        check(ack_drive == 1'b0, "R10 early stop ack", ack_drive, 0);

        // R9 data byte after ACK gives no second decision
        p0 = pulses;
        bus_start();
        bus_byte(8'h18);
        ack_slot(got, after);
        bus_byte(8'h18);
        ack_slot(got, after);
        bus_stop();
        check(pulses - p0 == 1, "R9 data no pulse", pulses - p0, 1);
        check(got == 1'b0, "R9 data no ack", got, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule